// File: doc/BRIEF.md
# Keypad Code Converter with Output Latch

This block sits behind the tone detector and the steering logic of a dual-tone keypad receiver. It takes the detected low-group row index and high-group column index and turns the pair into a 4-bit character code. When the steering logic issues a register strobe, the code is written into an output latch. Between strobes, the latch holds the last code that was accepted.

An inhibit input blocks the four extended characters in the rightmost keypad column. A strobe for one of those characters under inhibit leaves the latch untouched. It also raises no acceptance pulse, so the steering logic never signals that a new digit arrived.

The latched code is presented on a 4-bit data bus with a per-bit enable, meant for a tristate pad ring. When the output-enable input is low, the enable releases every bit.

Top module: `dtmf_digit_latch`

## Requirements
- R1: Row index 0..3 selects the low-group tones in ascending frequency order, and column index 0..3 selects the high-group tones in ascending order. The keypad rows are {1,2,3,A}, {4,5,6,B}, {7,8,9,C} and {*,0,#,D}, reading from column 0 to column 3.
- R2: Digits 1 through 9 are coded as their own binary value, 0001 through 1001.
- R3: Digit 0 is coded as 1010, star as 1011 and hash as 1100.
- R4: A is coded as 1101, B as 1110, C as 1111 and D as 0000.
- R5: The latch loads on a rising clock edge when `reg_stb` is high. Otherwise it keeps its value, whatever the row and column inputs do.
- R6: While `inhibit` is high, a strobe for A, B, C or D leaves the latch unchanged and produces no acceptance pulse. Strobes for other characters load as usual.
- R7: When `out_en` is low, `data_oe` is 0000. When it is high, `data_oe` is 1111 and `data_q` shows the latched code.
- R8: An active-low asynchronous reset clears the latch to 0000 and drops `accepted`.
- R9: `accepted` is high for exactly the one cycle after each edge at which a load really took place, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_idx | input | 2 | Low-group tone index, 0 = lowest frequency |
| col_idx | input | 2 | High-group tone index, 0 = lowest frequency |
| reg_stb | input | 1 | Register strobe from the steering logic |
| inhibit | input | 1 | Blocks the extended characters A to D |
| out_en | input | 1 | Output enable for the data bus |
| data_q | output | 4 | Latched character code |
| data_oe | output | 4 | Per-bit drive enable for the data pads |
| accepted | output | 1 | One-cycle pulse after a real load |

## Verification
The latch and `accepted` each pass through a single register. A strobe applied before a rising edge therefore shows up in `data_q` and `accepted` at the next falling edge. The bench drives every input on a falling edge and samples one full cycle later. It samples again one cycle after that to confirm that `accepted` has fallen and that the code has held. `data_oe` has no register in its path, so the bench checks it 1 ns after changing `out_en`, with no clock edge in between.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;
  localparam int IDX_W  = 2;
  localparam int CODE_W = 4;
  localparam int N_COLS = 1 << IDX_W;
  localparam int EXT_COL = N_COLS - 1;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [CODE_W-1:0] code_t;

  // Extended characters occupy the highest-frequency column.
  function automatic logic is_extended(input idx_t col);
    return (int'(col) == EXT_COL);
  endfunction

  // Row/column pair to character code.
  function automatic code_t key_code(input idx_t row, input idx_t col);
    code_t res;
    if (is_extended(col)) begin
      // A,B,C -> 13,14,15 ; D wraps to 0
      res = code_t'(13 + int'(row));
    end else if (int'(row) < 3) begin
      res = code_t'(int'(row) * 3 + int'(col) + 1);
    end else begin
      case (col)
        idx_t'(0): res = code_t'(11); // star
        idx_t'(1): res = code_t'(10); // zero
        default:   res = code_t'(12); // hash
      endcase
    end
    return res;
  endfunction
endpackage

// File: rtl/dtmf_key_encoder.sv
module dtmf_key_encoder
  import dtmf_pkg::*;
(
  input  idx_t  row_idx,
  input  idx_t  col_idx,
  output code_t code,
  output logic  ext_key
);
  always_comb begin
    code    = key_code(row_idx, col_idx);
    ext_key = is_extended(col_idx);
  end
endmodule

// File: rtl/dtmf_code_store.sv
module dtmf_code_store
  import dtmf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  reg_stb,
  input  logic  inhibit,
  input  code_t code_in,
  input  logic  ext_key,
  output code_t latch_q,
  output logic  accepted
);
  logic blocked;
  logic load_fire;

  assign blocked   = inhibit & ext_key;
  assign load_fire = reg_stb & ~blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q  <= '0;
      accepted <= 1'b0;
    end else begin
      accepted <= load_fire;
      if (load_fire) latch_q <= code_in;
    end
  end

  AST_HOLD_WITHOUT_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_stb |=> $stable(latch_q)); // R5
  AST_INHIBIT_BLOCKS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_stb && inhibit && ext_key) |=> ($stable(latch_q) && !accepted)); // R6
  AST_LOAD_TAKES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> (accepted && latch_q == $past(code_in))); // R9
  AST_ACCEPT_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |-> $past(reg_stb)); // R9
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (latch_q == '0 && !accepted)); // R8
endmodule

// File: rtl/dtmf_bus_drive.sv
module dtmf_bus_drive
  import dtmf_pkg::*;
(
  input  logic  out_en,
  input  code_t latch_q,
  output code_t data_q,
  output code_t data_oe
);
  for (genvar b = 0; b < CODE_W; b++) begin : g_bit
    assign data_q[b]  = latch_q[b];
    assign data_oe[b] = out_en;
  end

  always_comb begin
    if (!out_en) AST_RELEASED: assert (data_oe == '0); // R7
  end
endmodule

// File: rtl/dtmf_digit_latch.sv
module dtmf_digit_latch
  import dtmf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] row_idx,
  input  logic [IDX_W-1:0] col_idx,
  input  logic             reg_stb,
  input  logic             inhibit,
  input  logic             out_en,
  output logic [CODE_W-1:0] data_q,
  output logic [CODE_W-1:0] data_oe,
  output logic             accepted
);
  code_t enc_code;
  logic  enc_ext;
  code_t latch_q;

  dtmf_key_encoder u_enc (
    .row_idx(row_idx), .col_idx(col_idx), .code(enc_code), .ext_key(enc_ext)
  );

  dtmf_code_store u_store (
    .clk(clk), .rst_n(rst_n), .reg_stb(reg_stb), .inhibit(inhibit),
    .code_in(enc_code), .ext_key(enc_ext), .latch_q(latch_q), .accepted(accepted)
  );

  dtmf_bus_drive u_bus (
    .out_en(out_en), .latch_q(latch_q), .data_q(data_q), .data_oe(data_oe)
  );
endmodule

// File: tb/dtmf_digit_latch_test.sv
module dtmf_digit_latch_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] row_idx = '0;
  logic [1:0] col_idx = '0;
  logic       reg_stb = 1'b0;
  logic       inhibit = 1'b0;
  logic       out_en = 1'b1;
  logic [3:0] data_q;
  logic [3:0] data_oe;
  logic       accepted;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [3:0] model_q = 4'h0;

  dtmf_digit_latch uut (
    .clk(clk), .rst_n(rst_n), .row_idx(row_idx), .col_idx(col_idx),
    .reg_stb(reg_stb), .inhibit(inhibit), .out_en(out_en),
    .data_q(data_q), .data_oe(data_oe), .accepted(accepted)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp=<50000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Keypad legend, row-major, column 0 first (R1).
  function automatic byte key_char(input int r, input int c);
    string pad = "123A456B789C*0#D";
    return pad[r*4 + c];
  endfunction

  function automatic logic [3:0] char_code(input byte ch);
    case (ch)
      "0": return 4'b1010;
      "*": return 4'b1011;
      "#": return 4'b1100;
      "A": return 4'b1101;
      "B": return 4'b1110;
      "C": return 4'b1111;
      "D": return 4'b0000;
      default: return 4'(ch - "0");
    endcase
  endfunction

  task automatic press(input int r, input int c, input bit inh, input string req);
    byte ch = key_char(r, c);
    bit ext = (ch == "A" || ch == "B" || ch == "C" || ch == "D");
    bit loads = !(inh && ext);
    @(negedge clk);
    row_idx = 2'(r); col_idx = 2'(c); inhibit = inh; reg_stb = 1'b1;
    @(negedge clk);
    reg_stb = 1'b0;
    if (loads) model_q = char_code(ch);
    check(data_q == model_q, req, data_q, model_q);
    check(accepted == loads, "R9 pulse", accepted, loads);
    @(negedge clk);
    check(accepted == 1'b0, "R9 width", accepted, 0);
    check(data_q == model_q, "R5 hold", data_q, model_q);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(data_q == 4'h0, "R8 latch", data_q, 0);
    check(accepted == 1'b0, "R8 accepted", accepted, 0);
    rst_n = 1'b1;
    model_q = 4'h0;
  endtask

  task automatic t_all_keys();
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        byte ch = key_char(r, c);
        if (c == 3) press(r, c, 1'b0, "R4 ext code");
        else if (ch >= "1" && ch <= "9") press(r, c, 1'b0, "R2 digit");
        else press(r, c, 1'b0, "R3 zero/star/hash");
      end
  endtask

  task automatic t_hold();
    press(1, 1, 1'b0, "R1 key 5");
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      row_idx = 2'(k); col_idx = 2'(3 - k);
    end
    @(negedge clk);
    check(data_q == model_q, "R5 no strobe", data_q, model_q);
    check(accepted == 1'b0, "R5 no pulse", accepted, 0);
  endtask

  task automatic t_inhibit();
    press(2, 2, 1'b0, "R1 key 9");
    for (int r = 0; r < 4; r++) press(r, 3, 1'b1, "R6 ext blocked");
    press(3, 1, 1'b1, "R6 zero passes");
    press(0, 3, 1'b0, "R6 A after release");
  endtask

  task automatic t_enable();
    press(3, 2, 1'b0, "R3 hash");
    @(negedge clk);
    out_en = 1'b0;
    #1;
    check(data_oe == 4'b0000, "R7 released", data_oe, 0);
    out_en = 1'b1;
    #1;
    check(data_oe == 4'b1111, "R7 driven", data_oe, 15);
    check(data_q == 4'b1100, "R7 data", data_q, 12);
  endtask

  initial begin
    t_reset();
    t_all_keys();
    t_hold();
    t_inhibit();
    t_enable();
    press(2, 0, 1'b0, "R2 key 7");
    t_reset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule